// File: doc/BRIEF.md
# Serial Shift/Count Port

A four-bit serial register for a small controller core. It has two modes. In shift mode it takes one bit from the serial input on each instruction-cycle tick and shifts it in at the low end. The top bit can be presented on the serial data output, and a one-bit latch gates a sync pulse on the serial clock output once per cycle. This timing suits clocked serial memories. In count mode the register counts falling edges of the serial input, and the serial clock output follows the latch as a plain level.

The core reaches the register through an exchange request. The request writes the accumulator value into the register and loads the clock latch from carry. The old register contents are on `sio_o` in the cycle of the request, so the core captures them at the same edge. A separate write loads the four mode bits. Bit 0 selects count mode and bit 3 enables the serial data output.

Top module: `serial_port_unit`

## Requirements
- R1: After reset the register reads 0, the mode bits are 0 (shift mode), the clock latch is 1, and `sk_o` and `so_o` are 0.
- R2: In shift mode, a clock edge with `tick_i`=1 sets the register to ((old << 1) | `si_i`) mod 16. With `tick_i`=0 the register holds.
- R3: In count mode, a tick edge adds 1 (mod 16) when `si_i` is 0 and the `si_i` sampled at the previous tick was 1. Otherwise the register holds. The sample is taken at every tick in both modes.
- R4: An edge with `xchg_i`=1 loads the register from `acc_i` and the clock latch from `carry_i`. Exchange takes priority over a tick in the same cycle, but that tick still takes the `si_i` sample.
- R5: In count mode (mode bit 0 = 1), `sk_o` equals the clock latch after each edge.
- R6: In shift mode with the latch at 1, `sk_o` is 0 for the one clock after each tick edge and 1 after edges without a tick.
- R7: In shift mode with the latch at 0, `sk_o` stays 0.
- R8: A mode write (`mode_we_i`=1) and any latch load take effect on `sk_o` at the same edge that stores them.
- R9: `so_o` is `sio_o[3]` in shift mode when mode bit 3 is 1, and 0 in shift mode when mode bit 3 is 0. In count mode `so_o` equals mode bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-cycle tick |
| si_i | input | 1 | Serial input |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 4 | Mode value (bit 0 count mode, bit 3 output enable) |
| xchg_i | input | 1 | Exchange request |
| acc_i | input | 4 | Accumulator value to load |
| carry_i | input | 1 | Carry value loaded into the clock latch |
| sio_o | output | 4 | Register contents |
| so_o | output | 1 | Serial data output |
| sk_o | output | 1 | Serial clock output |

## Verification
The bench builds the block with its default four-bit width, so the wrap from 15 to 0 and the loss of the top bit on a shift are reached in a few cycles. One vector stream covers both modes, with latch values 0 and 1 and output enable on and off. It also places a tick and an exchange in the same cycle, to show that the exchange wins while the edge sample still advances. Directed runs then check the reset state, including an asynchronous reset in the middle of a run.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int unsigned MODE_W      = 4;
  localparam int unsigned MODE_CNT_B  = 0;  // 1: count mode
  localparam int unsigned MODE_SOEN_B = 3;  // serial data output enable
endpackage

// File: rtl/sio_datapath.sv
module sio_datapath #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             si_i,
  input  logic             count_mode_i,
  input  logic             so_en_i,
  input  logic             xchg_i,
  input  logic [WIDTH-1:0] acc_i,
  output logic [WIDTH-1:0] sio_o,
  output logic             so_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] sio_q, sio_d;
  logic             si_prev_q;
  logic             fall_edge;

  assign fall_edge = si_prev_q & ~si_i;

  always_comb begin
    sio_d = sio_q;
    if (xchg_i) begin
      sio_d = acc_i;
    end else if (tick_i) begin
      if (count_mode_i) begin
        if (fall_edge) sio_d = sio_q + WIDTH'(1);
      end else begin
        sio_d = {sio_q[MSB-1:0], si_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sio_q     <= '0;
      si_prev_q <= 1'b0;
    end else begin
      sio_q <= sio_d;
      if (tick_i) si_prev_q <= si_i;
    end
  end

  assign sio_o = sio_q;
  assign so_o  = count_mode_i ? so_en_i : (so_en_i & sio_q[MSB]);

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !xchg_i && !count_mode_i) |=> sio_q == {$past(sio_q[MSB-1:0]), $past(si_i)});

  assert_count_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !xchg_i) |=> $stable(sio_q));

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !xchg_i && count_mode_i && si_prev_q && !si_i) |=> sio_q == $past(sio_q) + WIDTH'(1));

  assert_xchg_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i |=> sio_q == $past(acc_i));
endmodule

// File: rtl/sk_driver.sv
module sk_driver (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic count_mode_d_i,  // mode value being stored at this edge
  input  logic xchg_i,
  input  logic carry_i,
  output logic sk_o
);
  logic skl_q, skl_d;
  logic sk_q, sk_d;
  logic cnt_q;

  assign skl_d = xchg_i ? carry_i : skl_q;
  // shift mode: sync pulse low for the clock after a tick, gated by latch
  assign sk_d  = count_mode_d_i ? skl_d : (skl_d & ~tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skl_q <= 1'b1;
      sk_q  <= 1'b0;
      cnt_q <= 1'b0;
    end else begin
      skl_q <= skl_d;
      sk_q  <= sk_d;
      cnt_q <= count_mode_d_i;
    end
  end

  assign sk_o = sk_q;

  assert_sk_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_mode_d_i && !xchg_i) |=> sk_q == $past(skl_q));

  assert_sk_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_mode_d_i && skl_d && tick_i) |=> !sk_q);

  assert_sk_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_q && !skl_q) |-> !sk_q);

  assert_latch_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i |=> skl_q == $past(carry_i));
endmodule

// File: rtl/serial_port_unit.sv
module serial_port_unit
  import serial_port_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              si_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              xchg_i,
  input  logic [WIDTH-1:0]  acc_i,
  input  logic              carry_i,
  output logic [WIDTH-1:0]  sio_o,
  output logic              so_o,
  output logic              sk_o
);
  logic [MODE_W-1:0] mode_q, mode_d;

  assign mode_d = mode_we_i ? mode_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_d;
  end

  sio_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .si_i         (si_i),
    .count_mode_i (mode_q[MODE_CNT_B]),
    .so_en_i      (mode_q[MODE_SOEN_B]),
    .xchg_i       (xchg_i),
    .acc_i        (acc_i),
    .sio_o        (sio_o),
    .so_o         (so_o)
  );

  sk_driver u_sk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .count_mode_d_i (mode_d[MODE_CNT_B]),
    .xchg_i         (xchg_i),
    .carry_i        (carry_i),
    .sk_o           (sk_o)
  );

  assert_so_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q[MODE_CNT_B] && !mode_q[MODE_SOEN_B]) |-> !so_o);

  assert_mode_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> mode_q == $past(mode_i));
endmodule

// File: tb/serial_port_unit_tb.sv
module serial_port_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i, si_i, mode_we_i, xchg_i, carry_i;
  logic [3:0] mode_i, acc_i;
  logic [3:0] sio_o;
  logic       so_o, sk_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  serial_port_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .si_i(si_i),
    .mode_we_i(mode_we_i), .mode_i(mode_i), .xchg_i(xchg_i),
    .acc_i(acc_i), .carry_i(carry_i), .sio_o(sio_o), .so_o(so_o), .sk_o(sk_o)
  );

  // {tick, si, mode_we, mode[3:0], xchg, acc[3:0], carry, exp_sio[3:0], exp_so, exp_sk}
  localparam int NV = 25;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h1,1'b0,1'b0}, // R2 R6
    {1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h1,1'b0,1'b1}, // R2 hold, R6 high
    {1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h2,1'b0,1'b0}, // R2
    {1'b1,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h5,1'b0,1'b0}, // R2
    {1'b1,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'hB,1'b0,1'b0}, // R2
    {1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h6,1'b0,1'b0}, // R2 top bit lost
    {1'b0,1'b0,1'b1,4'h8,1'b0,4'h0,1'b0, 4'h6,1'b0,1'b1}, // R9 R8
    {1'b1,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'hD,1'b1,1'b0}, // R9 R2
    {1'b0,1'b0,1'b0,4'h0,1'b1,4'h3,1'b0, 4'h3,1'b0,1'b0}, // R4 latch 0
    {1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h6,1'b0,1'b0}, // R7
    {1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h6,1'b0,1'b0}, // R7
    {1'b0,1'b0,1'b1,4'h1,1'b0,4'h0,1'b0, 4'h6,1'b0,1'b0}, // R5 R9 count mode
    {1'b0,1'b0,1'b0,4'h0,1'b1,4'h9,1'b1, 4'h9,1'b0,1'b1}, // R4 R5 R8
    {1'b1,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h9,1'b0,1'b1}, // R3 rising no count
    {1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'hA,1'b0,1'b1}, // R3 falling
    {1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'hA,1'b0,1'b1}, // R3 low hold
    {1'b1,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'hA,1'b0,1'b1}, // R3
    {1'b0,1'b0,1'b0,4'h0,1'b1,4'hF,1'b1, 4'hF,1'b0,1'b1}, // R4
    {1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b0,1'b1}, // R3 wrap
    {1'b0,1'b0,1'b1,4'h9,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1}, // R9 count so=bit3
    {1'b1,1'b1,1'b0,4'h0,1'b1,4'h5,1'b0, 4'h5,1'b1,1'b0}, // R4 priority, R5
    {1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h6,1'b1,1'b0}, // R3 sample kept
    {1'b0,1'b0,1'b1,4'h0,1'b0,4'h0,1'b0, 4'h6,1'b0,1'b0}, // R8 R7
    {1'b0,1'b0,1'b0,4'h0,1'b1,4'h2,1'b1, 4'h2,1'b0,1'b1}, // R4 R6 R8
    {1'b1,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h5,1'b0,1'b0}  // R6 R2
  };
  localparam int REQ [NV] = '{2,2,2,2,2,2,9,9,4,7,7,5,4,3,3,3,3,4,3,9,4,3,8,6,6};

  task automatic idle_inputs();
    tick_i = 0; si_i = 0; mode_we_i = 0; mode_i = 0;
    xchg_i = 0; acc_i = 0; carry_i = 0;
  endtask

  task automatic check(string tag, logic [3:0] esio, logic eso, logic esk);
    checks++;
    if (sio_o !== esio || so_o !== eso || sk_o !== esk) begin
      errors++;
      $display("FAIL %s: sio=%h so=%b sk=%b expected sio=%h so=%b sk=%b",
               tag, sio_o, so_o, sk_o, esio, eso, esk);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check("R1 reset", 4'h0, 1'b0, 1'b0);
    rst_ni = 1;

    for (int i = 0; i < NV; i++) begin
      {tick_i, si_i, mode_we_i, mode_i, xchg_i, acc_i, carry_i} = VEC[i][18:6];
      @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R%0d vec %0d", REQ[i], i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R1: async reset mid-run, latch back to 1, mode back to shift
    idle_inputs();
    xchg_i = 1; acc_i = 4'hC; carry_i = 0; mode_we_i = 1; mode_i = 4'h9;
    @(posedge clk_i); @(negedge clk_i);
    idle_inputs();
    #2 rst_ni = 0;
    #1 check("R1 async reset", 4'h0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1;
    @(posedge clk_i); @(negedge clk_i);
    check("R1 latch set after reset", 4'h0, 1'b0, 1'b1);
    tick_i = 1; si_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    check("R1 shift mode after reset", 4'h1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule